// File: doc/BRIEF.md
# JTAG Clock Synchronizer with Return Clock

This block connects an external JTAG port to a debug core that runs entirely on the system clock. The test clock coming from the debugger is never used as a clock. It is only sampled. The block passes it through a synchronizer and an edge detector. For every rising edge of the test clock it produces a single-cycle enable in the system clock domain, and it does the same for every falling edge. The TAP logic downstream advances only on these enables.

Serial data moves on the same enables. The incoming data bit is captured in the cycle where the rising-edge enable is high. The outgoing data pin is reloaded from the TAP only in the cycle where the falling-edge enable is high. As a result, the outgoing bit holds steady across the next rising edge of the test clock, which is where the debugger samples it.

The block also returns the synchronized, delayed copy of the test clock to the debugger as a return clock. An adaptive-clocking debugger waits for each test clock edge to appear on the return clock before it issues the next edge. This keeps the debugger in step with the core when the system clock frequency changes. The assertion of an asynchronous active-low reset is immediate, but its release is synchronized to the system clock.

Top module: `jtag_tck_sync`

## Requirements
- R1: While reset is asserted, and right after it is released with the test clock low, the rising enable, falling enable, captured data bit, outgoing data pin and return clock are all 0.
- R2: A low-to-high change of the test clock pin that is sampled at system clock edge n makes the rising enable high for exactly one cycle, after edge n+2, and low otherwise.
- R3: A high-to-low change of the test clock pin that is sampled at edge n makes the falling enable high for exactly one cycle, after edge n+2, and low otherwise.
- R4: After edge n, the return clock equals the test clock pin value sampled at edge n-2. Each of its rising transitions comes with the rising enable, and each of its falling transitions comes with the falling enable.
- R5: On the edge where the rising enable is high, the captured data bit takes the data input pin value. On every other edge it holds.
- R6: On the edge where the falling enable is high, the outgoing data pin takes the TAP output bit. On every other edge it holds, including across rising enables.
- R7: The two enables are never high together. When every high and low phase of the test clock lasts at least 4 system clock cycles, the number of rising enables equals the number of test clock rising edges and no edge is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset, released synchronously |
| tckPin | input | 1 | Test clock from the debugger (asynchronous) |
| tdiPin | input | 1 | Serial data in from the debugger |
| tapTdoBit | input | 1 | Next serial output bit from the TAP logic |
| tapRiseEn | output | 1 | One-cycle enable per test clock rising edge |
| tapFallEn | output | 1 | One-cycle enable per test clock falling edge |
| tapTdiBit | output | 1 | Data-in bit captured on the rising enable |
| tdoPin | output | 1 | Serial data out to the debugger |
| rtckPin | output | 1 | Return clock to the debugger |

## Verification
The test clock is driven with phases at the 4-cycle minimum, with unequal long and short phases, and with pseudo-random phase lengths from 4 to 11 cycles. The minimum-phase runs show whether back-to-back edges are merged or dropped. The unequal runs separate the rising path from the falling path. The data input and the TAP output bit change at arbitrary cycles, including while an enable is pending. This shows whether capture and launch happen only in the enable cycle and not on the raw test clock edge. A directed run counts edges from a test clock change to each enable and to the return clock, to confirm the 3-cycle delay.

// File: rtl/jtag_tck_sync_pkg.sv
package jtag_tck_sync_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } tapStrobes_t;
endpackage

// File: rtl/jtag_rst_sync.sv
module jtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic rstSyncN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstSyncN = chain[STAGES-1];
endmodule

// File: rtl/jtag_edge_ctrl.sv
module jtag_edge_ctrl
  import jtag_tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tckPin,
  output tapStrobes_t strobes,
  output logic        tckDelayed
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   tckSync;
  logic                   tckPrev;

  // first stage samples the asynchronous pin, later stages resolve metastability
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= tckPin;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign tckSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tckPrev      <= 1'b0;
      strobes.rise <= 1'b0;
      strobes.fall <= 1'b0;
    end else begin
      tckPrev      <= tckSync;
      strobes.rise <= tckSync & ~tckPrev;
      strobes.fall <= ~tckSync & tckPrev;
    end
  end

  assign tckDelayed = tckPrev;
endmodule

// File: rtl/jtag_data_path.sv
module jtag_data_path
  import jtag_tck_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tapStrobes_t strobes,
  input  logic        tdiPin,
  input  logic        tapTdoBit,
  output logic        tdiBit,
  output logic        tdoBit
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tdiBit <= 1'b0;
    else if (strobes.rise) tdiBit <= tdiPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tdoBit <= 1'b0;
    else if (strobes.fall) tdoBit <= tapTdoBit;
  end
endmodule

// File: rtl/jtag_tck_sync.sv
module jtag_tck_sync
  import jtag_tck_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tckPin,
  input  logic tdiPin,
  input  logic tapTdoBit,
  output logic tapRiseEn,
  output logic tapFallEn,
  output logic tapTdiBit,
  output logic tdoPin,
  output logic rtckPin
);
  logic        rstSyncN;
  tapStrobes_t strobes;

  jtag_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rstN(rstN), .rstSyncN(rstSyncN)
  );

  jtag_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstSyncN), .tckPin(tckPin),
    .strobes(strobes), .tckDelayed(rtckPin)
  );

  jtag_data_path i_data (
    .clk(clk), .rstN(rstSyncN), .strobes(strobes),
    .tdiPin(tdiPin), .tapTdoBit(tapTdoBit),
    .tdiBit(tapTdiBit), .tdoBit(tdoPin)
  );

  assign tapRiseEn = strobes.rise;
  assign tapFallEn = strobes.fall;
endmodule

// File: rtl/jtag_tck_sync_checker.sv
module jtag_tck_sync_checker (
  input logic clk,
  input logic rstN,
  input logic tdiPin,
  input logic tapTdoBit,
  input logic tapRiseEn,
  input logic tapFallEn,
  input logic tapTdiBit,
  input logic tdoPin,
  input logic rtckPin
);
  // R2: a rising enable coincides with the return clock having just risen
  assert_rise_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    tapRiseEn |-> (rtckPin && !$past(rtckPin)));

  // R3: a falling enable coincides with the return clock having just fallen
  assert_fall_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    tapFallEn |-> (!rtckPin && $past(rtckPin)));

  // R4: every return clock rise is announced by the rising enable
  assert_rtck_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtckPin) |-> tapRiseEn);

  // R4: every return clock fall is announced by the falling enable
  assert_rtck_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rtckPin) |-> tapFallEn);

  // R5: capture only in the rising enable cycle
  assert_tdi_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    tapRiseEn |=> (tapTdiBit == $past(tdiPin)));

  assert_tdi_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tapRiseEn |=> $stable(tapTdiBit));

  // R6: launch only in the falling enable cycle
  assert_tdo_launch_R6: assert property (@(posedge clk) disable iff (!rstN)
    tapFallEn |=> (tdoPin == $past(tapTdoBit)));

  assert_tdo_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !tapFallEn |=> $stable(tdoPin));

  // R7: enables are mutually exclusive
  assert_enables_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tapRiseEn, tapFallEn}));

  // R2: a rising enable lasts a single cycle
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    tapRiseEn |=> !tapRiseEn);

  // R3: a falling enable lasts a single cycle
  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    tapFallEn |=> !tapFallEn);
endmodule

bind jtag_tck_sync jtag_tck_sync_checker i_checker (
  .clk(clk), .rstN(rstN), .tdiPin(tdiPin), .tapTdoBit(tapTdoBit),
  .tapRiseEn(tapRiseEn), .tapFallEn(tapFallEn), .tapTdiBit(tapTdiBit),
  .tdoPin(tdoPin), .rtckPin(rtckPin)
);

// File: tb/test_jtag_tck_sync.sv
`timescale 1ns/1ps
module test_jtag_tck_sync;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tckPin = 1'b0;
  logic tdiPin = 1'b0;
  logic tapTdoBit = 1'b0;
  logic tapRiseEn, tapFallEn, tapTdiBit, tdoPin, rtckPin;

  int checks = 0;
  int errors = 0;
  int risesDriven = 0;
  int risesSeen = 0;
  int fallsDriven = 0;
  int fallsSeen = 0;
  bit done = 1'b0;
  bit compareOn = 1'b0;

  // behavioural reference: recent pin samples plus expected outputs
  bit h0 = 0, h1 = 0, h2 = 0, h3 = 0;
  bit expRise = 0, expFall = 0, expTdi = 0, expTdo = 0, expRtck = 0;

  always #2 clk = ~clk;

  jtag_tck_sync i_jtag_tck_sync (
    .clk(clk), .rstN(rstN), .tckPin(tckPin), .tdiPin(tdiPin),
    .tapTdoBit(tapTdoBit), .tapRiseEn(tapRiseEn), .tapFallEn(tapFallEn),
    .tapTdiBit(tapTdiBit), .tdoPin(tdoPin), .rtckPin(rtckPin)
  );

  task automatic check(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      h0 = 0; h1 = 0; h2 = 0; h3 = 0;
      expRise = 0; expFall = 0; expTdi = 0; expTdo = 0; expRtck = 0;
    end else begin
      if (expRise) expTdi = tdiPin;
      if (expFall) expTdo = tapTdoBit;
      h3 = h2; h2 = h1; h1 = h0; h0 = tckPin;
      expRtck = h2;
      expRise = h2 & ~h3;
      expFall = ~h2 & h3;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      check("R2", "riseEn", tapRiseEn, expRise);
      check("R3", "fallEn", tapFallEn, expFall);
      check("R4", "rtck", rtckPin, expRtck);
      check("R5", "tdiBit", tapTdiBit, expTdi);
      check("R6", "tdoPin", tdoPin, expTdo);
      if (tapRiseEn && tapFallEn) check("R7", "both enables", 1'b1, 1'b0);
      if (tapRiseEn) risesSeen++;
      if (tapFallEn) fallsSeen++;
    end
  end

  task automatic tckPhase(input bit level, input int cycles);
    @(negedge clk);
    if (level && !tckPin) risesDriven++;
    if (!level && tckPin) fallsDriven++;
    tckPin = level;
    for (int i = 1; i < cycles; i++) begin
      @(negedge clk);
      if (i == 2) tdiPin = ~tdiPin ^ tapTdoBit;
      if (i == 1) tapTdoBit = ~tapTdoBit;
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] lfsr;
    int lat;
    repeat (3) @(negedge clk);
    check("R1", "rise in reset", tapRiseEn, 1'b0);
    check("R1", "fall in reset", tapFallEn, 1'b0);
    check("R1", "tdi in reset", tapTdiBit, 1'b0);
    check("R1", "tdo in reset", tdoPin, 1'b0);
    check("R1", "rtck in reset", rtckPin, 1'b0);
    @(negedge clk) rstN = 1'b1;
    repeat (8) @(negedge clk);
    check("R1", "rtck after release", rtckPin, 1'b0);
    check("R1", "tdo after release", tdoPin, 1'b0);
    compareOn = 1'b1;

    // R2: directed latency count from pin change to enable
    @(negedge clk) begin tckPin = 1'b1; risesDriven++; end
    lat = 0;
    while (!tapRiseEn && lat < 10) begin @(negedge clk); lat++; end
    check("R2", "rise latency is 3 edges", lat == 3, 1'b1);
    check("R4", "rtck high with rise enable", rtckPin, 1'b1);
    repeat (4) @(negedge clk);
    @(negedge clk) begin tckPin = 1'b0; fallsDriven++; end
    lat = 0;
    while (!tapFallEn && lat < 10) begin @(negedge clk); lat++; end
    check("R3", "fall latency is 3 edges", lat == 3, 1'b1);
    repeat (4) @(negedge clk);

    // minimum phases
    for (int k = 0; k < 40; k++) begin tckPhase(1, 4); tckPhase(0, 4); end
    // unequal phases
    for (int k = 0; k < 30; k++) begin tckPhase(1, 11); tckPhase(0, 4); end
    for (int k = 0; k < 30; k++) begin tckPhase(1, 4); tckPhase(0, 9); end
    // pseudo-random phases 4..11
    lfsr = 8'hA5;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tckPhase(1, 4 + int'(lfsr[2:0]));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tckPhase(0, 4 + int'(lfsr[2:0]));
    end
    repeat (8) @(negedge clk);

    // R7: no lost edge
    check("R7", "rising enables match rises", risesSeen == risesDriven, 1'b1);
    check("R7", "falling enables match falls", fallsSeen == fallsDriven, 1'b1);

    // R1: reset mid-run clears everything
    @(negedge clk) begin compareOn = 1'b0; rstN = 1'b0; tckPin = 1'b0; tapTdoBit = 1'b0; end
    @(negedge clk);
    check("R1", "tdo cleared by reset", tdoPin, 1'b0);
    check("R1", "rtck cleared by reset", rtckPin, 1'b0);
    check("R1", "tdi cleared by reset", tapTdiBit, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule